// File: doc/BRIEF.md
# Two-Wire Serial Slave Interface

This block is the slave end of a two-wire synchronous serial link with SMBus/I2C-style framing. It sits behind open-drain clock and data pads. It reads the sampled pad levels and returns only pull-low enables, so it never drives either line high. It follows whatever clock the master produces and recognises start and stop conditions. It answers only to its own 7-bit address, which is a parameter. It moves bytes most significant bit first, with an acknowledge slot after every byte.

The local side uses a byte handshake. A received byte is offered on a valid flag. A byte to be sent is requested on a request flag. While either flag is waiting, the block holds the bus clock low, which stalls the master until the local logic has taken or supplied the byte.

The data line must stay stable while the clock is high. If it moves in that phase part-way through a byte, the block drops the transfer and releases the data line, so every later acknowledge slot reads as NACK. It also latches a sticky error flag, which the local side clears with a one-cycle strobe.

Top module: `tw_slave`

## Requirements
- R1: After reset, both pull-low enables are off, the error flag is 0, and neither `rx_valid_o` nor `tx_req_o` is asserted.
- R2: An address byte carries the address in bits 7:1 and the direction in bit 0 (1 = read). If bits 7:1 equal `OWN_ADDR`, the block pulls SDA low in the following acknowledge slot. Otherwise it leaves SDA released for every later bit and acknowledge slot until the next start.
- R3: In a write, each data byte is assembled MSB first from SDA levels sampled while SCL is high. The byte appears on `rx_data_o` together with `rx_valid_o`.
- R4: After the eighth bit of a written byte, SCL is held low with `rx_valid_o` high until `rx_take_i` is seen. The block then releases SCL and acknowledges the byte by pulling SDA low.
- R5: In a read, after the address acknowledge and after each acknowledged byte, the block raises `tx_req_o` and holds SCL low until `tx_valid_i`. It then sends `tx_data_i` MSB first. A pulled SDA means a 0 bit.
- R6: A NACK from the master after a read byte ends transmission. SDA stays released and no further byte is requested until a stop or a repeated start.
- R7: An SDA transition while SCL is high, once two or more bits of a byte have been clocked, aborts the transfer. SDA and SCL are released, later acknowledge slots read as NACK, and `bus_err_o` is set. The flag stays set across later transactions.
- R8: `bus_err_clr_i` clears `bus_err_o` on the next clock. If an error is detected in the same cycle as the clear strobe, the flag stays set.
- R9: An SDA fall while SCL is high, outside the error window of R7, is a start or repeated start and restarts address reception. An SDA rise in the same window is a stop and returns the block to idle.
- R10: The block changes SDA from released to pulled only while the SCL line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the bus clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Sampled level of the clock pad |
| sda_i | input | 1 | Sampled level of the data pad |
| scl_pull_o | output | 1 | 1 pulls the clock line low (stretch) |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| rx_data_o | output | 8 | Last byte received in a write |
| rx_valid_o | output | 1 | Received byte waiting for the local side |
| rx_take_i | input | 1 | Local side has stored `rx_data_o` |
| tx_data_i | input | 8 | Byte to transmit |
| tx_valid_i | input | 1 | `tx_data_i` is valid while `tx_req_o` is high |
| tx_req_o | output | 1 | Block waits for a byte to transmit |
| bus_err_o | output | 1 | Sticky bus-error flag |
| bus_err_clr_i | input | 1 | Clear strobe for `bus_err_o` |

## Verification
The two functions that can meet in one cycle are the detection of a mid-byte data-line change, which sets the error flag, and the local clear strobe, which resets it. The bench toggles SDA while SCL is high in the middle of a written byte. It holds the clear strobe across the cycle in which the change reaches the detector and the cycle before it. The bench's own per-clock model predicts the flag, and the flag must stay set after that cycle. The other checks cover a plain clear, which must drop the flag, and the flag staying set through a later clean transaction.

// File: rtl/tw_pkg.sv
// Shared types for the two-wire slave: protocol state and bus events.
package tw_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BIT,
        ST_WR_HOLD,
        ST_WR_ACK,
        ST_RD_HOLD,
        ST_RD_BIT,
        ST_RD_ACK,
        ST_SKIP
    } tw_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
    } tw_evt_t;

endpackage

// File: rtl/tw_sync.sv
// Multi-stage synchroniser for asynchronous pad levels.
// Assumes the inputs idle high, so every stage resets to 1.
module tw_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][W-1:0] pipe;

    // Shift the pad levels through the synchroniser stages.
    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) pipe <= '1;
                else        pipe <= d_i;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) pipe <= '1;
                else        pipe <= {pipe[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = pipe[LAST];
endmodule

// File: rtl/tw_cond.sv
// Bus event detector: clock edges plus start and stop conditions.
// Assumes synchronised inputs. A start or stop needs SCL high on two
// successive samples, so a data change that arrives together with a
// clock rise is never taken as a condition.
module tw_cond
    import tw_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    scl_s,
    input  logic    sda_s,
    output tw_evt_t evt_o
);
    logic scl_q;
    logic sda_q;
    logic hi;

    // Keep the previous synchronised levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    // Decode edges and conditions from old and new levels.
    always_comb begin
        hi             = scl_s & scl_q;
        evt_o.scl_rise = scl_s & ~scl_q;
        evt_o.scl_fall = ~scl_s & scl_q;
        evt_o.start    = hi & sda_q & ~sda_s;
        evt_o.stop     = hi & ~sda_q & sda_s;
    end
endmodule

// File: rtl/tw_engine.sv
// Protocol engine: address match, byte shifting, acknowledge, clock
// stretch, abort on mid-byte data change, and the sticky error flag.
// Assumes events from tw_cond and a system clock at least 8x SCL.
module tw_engine
    import tw_pkg::*;
#(
    parameter logic [ADDR_W-1:0] OWN_ADDR = 7'h52
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tw_evt_t           evt_i,
    input  logic              sda_s,
    input  logic              rx_take_i,
    input  logic [BYTE_W-1:0] tx_data_i,
    input  logic              tx_valid_i,
    input  logic              err_clr_i,
    output logic              scl_pull_o,
    output logic              sda_pull_o,
    output logic [BYTE_W-1:0] rx_data_o,
    output logic              rx_valid_o,
    output logic              tx_req_o,
    output logic              bus_err_o
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] ERR_MIN = CNT_W'(2);

    tw_state_e         state;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] sh;
    logic              rd;
    logic              mack;
    logic              in_byte;
    logic              mid_byte;
    logic              moved;

    // Flag a data-line move while SCL is high inside the error window.
    always_comb begin
        in_byte  = (state == ST_ADDR) || (state == ST_WR_BIT) || (state == ST_RD_BIT);
        mid_byte = in_byte && (cnt >= ERR_MIN);
        moved    = evt_i.start | evt_i.stop;
    end

    // Main protocol sequencer; conditions take priority over bit events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            sh         <= '0;
            rd         <= 1'b0;
            mack       <= 1'b0;
            scl_pull_o <= 1'b0;
            sda_pull_o <= 1'b0;
            rx_data_o  <= '0;
            bus_err_o  <= 1'b0;
        end else begin
            if (err_clr_i) bus_err_o <= 1'b0;
            if (moved && mid_byte) begin
                bus_err_o  <= 1'b1;
                state      <= ST_SKIP;
                sda_pull_o <= 1'b0;
                scl_pull_o <= 1'b0;
            end else if (evt_i.start) begin
                state      <= ST_ADDR;
                cnt        <= '0;
                sda_pull_o <= 1'b0;
                scl_pull_o <= 1'b0;
            end else if (evt_i.stop) begin
                state      <= ST_IDLE;
                sda_pull_o <= 1'b0;
                scl_pull_o <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR: begin
                        if (evt_i.scl_rise) begin
                            sh  <= {sh[BYTE_W-2:0], sda_s};
                            cnt <= cnt + 1'b1;
                        end else if (evt_i.scl_fall && cnt == FULL) begin
                            if (sh[BYTE_W-1:1] == OWN_ADDR) begin
                                rd         <= sh[0];
                                sda_pull_o <= 1'b1;
                                state      <= ST_ADDR_ACK;
                            end else begin
                                state <= ST_SKIP;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (evt_i.scl_fall) begin
                            sda_pull_o <= 1'b0;
                            cnt        <= '0;
                            if (rd) begin
                                scl_pull_o <= 1'b1;
                                state      <= ST_RD_HOLD;
                            end else begin
                                state <= ST_WR_BIT;
                            end
                        end
                    end
                    ST_WR_BIT: begin
                        if (evt_i.scl_rise) begin
                            sh  <= {sh[BYTE_W-2:0], sda_s};
                            cnt <= cnt + 1'b1;
                        end else if (evt_i.scl_fall && cnt == FULL) begin
                            rx_data_o  <= sh;
                            scl_pull_o <= 1'b1;
                            state      <= ST_WR_HOLD;
                        end
                    end
                    ST_WR_HOLD: begin
                        if (rx_take_i) begin
                            sda_pull_o <= 1'b1;
                            scl_pull_o <= 1'b0;
                            state      <= ST_WR_ACK;
                        end
                    end
                    ST_WR_ACK: begin
                        if (evt_i.scl_fall) begin
                            sda_pull_o <= 1'b0;
                            cnt        <= '0;
                            state      <= ST_WR_BIT;
                        end
                    end
                    ST_RD_HOLD: begin
                        if (tx_valid_i) begin
                            sh         <= tx_data_i;
                            sda_pull_o <= ~tx_data_i[BYTE_W-1];
                            scl_pull_o <= 1'b0;
                            cnt        <= '0;
                            state      <= ST_RD_BIT;
                        end
                    end
                    ST_RD_BIT: begin
                        if (evt_i.scl_rise) begin
                            cnt <= cnt + 1'b1;
                        end else if (evt_i.scl_fall) begin
                            if (cnt == FULL) begin
                                sda_pull_o <= 1'b0;
                                state      <= ST_RD_ACK;
                            end else begin
                                sh         <= {sh[BYTE_W-2:0], 1'b0};
                                sda_pull_o <= ~sh[BYTE_W-2];
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (evt_i.scl_rise) begin
                            mack <= ~sda_s;
                        end else if (evt_i.scl_fall) begin
                            if (mack) begin
                                scl_pull_o <= 1'b1;
                                state      <= ST_RD_HOLD;
                            end else begin
                                state <= ST_SKIP;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Local handshake flags follow the waiting states.
    assign rx_valid_o = (state == ST_WR_HOLD);
    assign tx_req_o   = (state == ST_RD_HOLD);
endmodule

// File: rtl/tw_slave.sv
// Two-wire serial slave top: synchroniser, condition detector and
// protocol engine. Pads are open-drain; outputs are pull-low enables.
// Assumes clk runs at least 8x the bus clock.
module tw_slave #(
    parameter logic [6:0] OWN_ADDR    = 7'h52,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_pull_o,
    output logic       sda_pull_o,
    output logic [7:0] rx_data_o,
    output logic       rx_valid_o,
    input  logic       rx_take_i,
    input  logic [7:0] tx_data_i,
    input  logic       tx_valid_i,
    output logic       tx_req_o,
    output logic       bus_err_o,
    input  logic       bus_err_clr_i
);
    import tw_pkg::*;

    logic [1:0] pads_s;
    tw_evt_t    evt;

    tw_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({scl_i, sda_i}),
        .q_o   (pads_s)
    );

    tw_cond u_cond (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_s (pads_s[1]),
        .sda_s (pads_s[0]),
        .evt_o (evt)
    );

    tw_engine #(.OWN_ADDR(OWN_ADDR)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt),
        .sda_s      (pads_s[0]),
        .rx_take_i  (rx_take_i),
        .tx_data_i  (tx_data_i),
        .tx_valid_i (tx_valid_i),
        .err_clr_i  (bus_err_clr_i),
        .scl_pull_o (scl_pull_o),
        .sda_pull_o (sda_pull_o),
        .rx_data_o  (rx_data_o),
        .rx_valid_o (rx_valid_o),
        .tx_req_o   (tx_req_o),
        .bus_err_o  (bus_err_o)
    );
endmodule

// File: rtl/tw_slave_chk.sv
// Property checker for tw_slave, attached through bind.
// Relates the pad enables, the handshake flags and the error flag over time.
module tw_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic scl_pull_o,
    input logic sda_pull_o,
    input logic rx_valid_o,
    input logic tx_req_o,
    input logic bus_err_o,
    input logic bus_err_clr_i
);
    p_reset_release_r1: assert property (@(posedge clk)
        !rst_n |=> (!scl_pull_o && !sda_pull_o && !bus_err_o && !rx_valid_o && !tx_req_o));

    p_rx_stretch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> scl_pull_o);

    p_tx_stretch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req_o |-> scl_pull_o);

    p_stall_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        scl_pull_o |-> (rx_valid_o || tx_req_o));

    p_drive_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> !$past(scl_i));

    p_err_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_err_o) |-> (!sda_pull_o && !scl_pull_o));

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_err_o && !bus_err_clr_i) |=> bus_err_o);

    p_err_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_err_o) |-> $past(bus_err_clr_i));
endmodule

bind tw_slave tw_slave_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_i         (scl_i),
    .scl_pull_o    (scl_pull_o),
    .sda_pull_o    (sda_pull_o),
    .rx_valid_o    (rx_valid_o),
    .tx_req_o      (tx_req_o),
    .bus_err_o     (bus_err_o),
    .bus_err_clr_i (bus_err_clr_i)
);

// File: tb/tb_tw_slave.sv
`timescale 1ns/1ps
// Bench for tw_slave: a behavioural bus master, local responders with
// queues, and a per-clock model of the error flag and drive rules.
module tb_tw_slave;
    localparam logic [6:0] ADDR = 7'h52;
    localparam int HQ = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic scl_line, sda_line;
    logic scl_pull_o, sda_pull_o, rx_valid_o, tx_req_o, bus_err_o;
    logic [7:0] rx_data_o;
    logic rx_take_i = 1'b0;
    logic [7:0] tx_data_i = 8'h00;
    logic tx_valid_i = 1'b0;
    logic bus_err_clr_i = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit exp_err = 1'b0;
    bit mon_on = 1'b0;
    bit done = 1'b0;
    int rx_delay = 3;
    int tx_delay = 5;
    int rx_wait = 0;
    int tx_wait = 0;
    int tx_reqs = 0;
    int run = 0;
    int max_run = 0;
    logic prev_scl = 1'b1;
    logic prev_sdap = 1'b0;
    logic [7:0] rx_q[$];
    logic [7:0] tx_q[$];

    always #4 clk = ~clk;

    assign scl_line = m_scl & ~scl_pull_o;
    assign sda_line = m_sda & ~sda_pull_o;

    tw_slave #(.OWN_ADDR(ADDR)) dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .scl_pull_o(scl_pull_o), .sda_pull_o(sda_pull_o),
        .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o), .rx_take_i(rx_take_i),
        .tx_data_i(tx_data_i), .tx_valid_i(tx_valid_i), .tx_req_o(tx_req_o),
        .bus_err_o(bus_err_o), .bus_err_clr_i(bus_err_clr_i)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Local receive side: store the byte after rx_delay cycles.
    always @(negedge clk) begin
        if (rx_take_i) rx_take_i = 1'b0;
        else if (rx_valid_o) begin
            rx_wait++;
            if (rx_wait >= rx_delay) begin
                rx_q.push_back(rx_data_o);
                rx_take_i = 1'b1;
                rx_wait = 0;
            end
        end
    end

    // Local transmit side: supply a queued byte after tx_delay cycles.
    always @(negedge clk) begin
        if (tx_valid_i) tx_valid_i = 1'b0;
        else if (tx_req_o) begin
            tx_wait++;
            if (tx_wait >= tx_delay) begin
                tx_data_i = (tx_q.size() > 0) ? tx_q.pop_front() : 8'hFF;
                tx_valid_i = 1'b1;
                tx_wait = 0;
                tx_reqs++;
            end
        end
    end

    // Per-clock comparison against the model.
    always @(posedge clk) begin
        #2;
        if (mon_on) begin
            check(bus_err_o == exp_err, "R7/R8 error flag vs model", bus_err_o, exp_err);
            check(!(sda_pull_o && !prev_sdap && prev_scl), "R10 SDA pulled while SCL high",
                  prev_scl, 0);
            check(!(rx_valid_o && tx_req_o), "R4/R5 single wait cause", tx_req_o, 0);
            if (scl_pull_o) run++; else run = 0;
            if (run > max_run) max_run = run;
        end
        prev_scl = scl_line;
        prev_sdap = sda_pull_o;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic scl_high();
        m_scl = 1'b1;
        do @(negedge clk); while (scl_line !== 1'b1);
    endtask

    task automatic bit_xfer(input logic b, output logic s);
        m_sda = b;
        tick(HQ);
        scl_high();
        tick(HQ);
        s = sda_line;
        tick(HQ);
        m_scl = 1'b0;
        tick(HQ);
    endtask

    task automatic do_start();
        m_sda = 1'b1;
        tick(HQ);
        scl_high();
        tick(HQ);
        m_sda = 1'b0;
        tick(HQ);
        m_scl = 1'b0;
        tick(HQ);
    endtask

    task automatic do_stop();
        m_sda = 1'b0;
        tick(HQ);
        scl_high();
        tick(HQ);
        m_sda = 1'b1;
        tick(2 * HQ);
    endtask

    task automatic wr_byte(input logic [7:0] d, output bit ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_xfer(d[i], s);
        bit_xfer(1'b1, s);
        ack = !s;
    endtask

    task automatic rd_byte(input bit give_ack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_xfer(1'b1, s);
            d[i] = s;
        end
        bit_xfer(!give_ack, s);
    endtask

    // Write a byte, moving SDA while SCL is high during its fourth bit.
    task automatic err_byte(input bit with_clr, output bit ack);
        logic s;
        bit_xfer(1'b1, s);
        bit_xfer(1'b0, s);
        bit_xfer(1'b1, s);
        m_sda = 1'b1;
        tick(HQ);
        scl_high();
        tick(HQ);
        m_sda = 1'b0;
        tick(1);
        if (with_clr) bus_err_clr_i = 1'b1;
        tick(1);
        exp_err = 1'b1;
        tick(1);
        bus_err_clr_i = 1'b0;
        tick(HQ);
        m_scl = 1'b0;
        tick(HQ);
        for (int i = 0; i < 4; i++) bit_xfer(1'b0, s);
        bit_xfer(1'b1, s);
        ack = !s;
    endtask

    task automatic clr_err();
        bus_err_clr_i = 1'b1;
        exp_err = 1'b0;
        tick(1);
        bus_err_clr_i = 1'b0;
        tick(2);
    endtask

    initial begin : wdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog (run) actual=hung expected=complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        bit ack;
        logic [7:0] d;
        tick(5);
        rst_n = 1'b1;
        tick(3);
        // R1: idle outputs after reset
        check(!scl_pull_o && !sda_pull_o, "R1 pull enables", {scl_pull_o, sda_pull_o}, 0);
        check(!bus_err_o && !rx_valid_o && !tx_req_o, "R1 flags",
              {bus_err_o, rx_valid_o, tx_req_o}, 0);
        mon_on = 1'b1;

        // R2: foreign address is ignored through following bytes
        do_start();
        wr_byte({7'h40, 1'b0}, ack);
        check(!ack, "R2 foreign address NACK", ack, 0);
        wr_byte(8'h11, ack);
        check(!ack && rx_q.size() == 0, "R2 silent after mismatch", ack, 0);
        do_stop();

        // R2, R3, R4: write two bytes with a slow local receiver
        rx_delay = 30;
        do_start();
        wr_byte({ADDR, 1'b0}, ack);
        check(ack, "R2 own address ACK", ack, 1);
        wr_byte(8'hA5, ack);
        check(ack, "R4 write byte ACK", ack, 1);
        wr_byte(8'h3C, ack);
        check(ack, "R4 second write ACK", ack, 1);
        do_stop();
        check(rx_q.size() == 2, "R3 byte count", rx_q.size(), 2);
        if (rx_q.size() == 2) begin
            check(rx_q[0] == 8'hA5, "R3 first byte MSB first", rx_q[0], 8'hA5);
            check(rx_q[1] == 8'h3C, "R3 second byte", rx_q[1], 8'h3C);
        end
        check(max_run >= 30, "R4 clock held until taken", max_run, 30);
        rx_q.delete();
        rx_delay = 3;

        // R5, R6: read two bytes, NACK ends transmission
        tx_reqs = 0;
        tx_q.push_back(8'h96);
        tx_q.push_back(8'h5B);
        do_start();
        wr_byte({ADDR, 1'b1}, ack);
        check(ack, "R2 read address ACK", ack, 1);
        rd_byte(1'b1, d);
        check(d == 8'h96, "R5 first read byte", d, 8'h96);
        rd_byte(1'b0, d);
        check(d == 8'h5B, "R5 second read byte", d, 8'h5B);
        rd_byte(1'b0, d);
        check(d == 8'hFF, "R6 SDA released after NACK", d, 8'hFF);
        check(tx_reqs == 2, "R6 no request after NACK", tx_reqs, 2);
        do_stop();

        // R9: repeated start switches from write to read
        tx_q.push_back(8'hC3);
        do_start();
        wr_byte({ADDR, 1'b0}, ack);
        wr_byte(8'h77, ack);
        check(ack, "R9 write before restart", ack, 1);
        do_start();
        wr_byte({ADDR, 1'b1}, ack);
        check(ack, "R9 address after repeated start", ack, 1);
        rd_byte(1'b0, d);
        check(d == 8'hC3, "R9 read after repeated start", d, 8'hC3);
        do_stop();
        check(rx_q.size() == 1 && rx_q[0] == 8'h77, "R9 written byte", rx_q.size(), 1);
        rx_q.delete();

        // R7: mid-byte data change aborts and sets the flag
        do_start();
        wr_byte({ADDR, 1'b0}, ack);
        err_byte(1'b0, ack);
        check(!ack, "R7 NACK after abort", ack, 0);
        check(bus_err_o, "R7 error flag set", bus_err_o, 1);
        do_stop();
        check(rx_q.size() == 0, "R7 no byte delivered", rx_q.size(), 0);

        // R7: flag survives a clean transaction
        do_start();
        wr_byte({ADDR, 1'b0}, ack);
        wr_byte(8'h0F, ack);
        check(ack, "R7 recovery ACK", ack, 1);
        do_stop();
        check(bus_err_o, "R7 flag sticky", bus_err_o, 1);
        rx_q.delete();

        // R8: clear, then error and clear in the same cycle
        clr_err();
        check(!bus_err_o, "R8 clear strobe", bus_err_o, 0);
        do_start();
        wr_byte({ADDR, 1'b0}, ack);
        err_byte(1'b1, ack);
        do_stop();
        check(bus_err_o, "R8 set wins over clear", bus_err_o, 1);
        clr_err();
        check(!bus_err_o, "R8 final clear", bus_err_o, 0);

        tick(10);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule